// File: doc/BRIEF.md
# Socket Interrupt Aggregator

This block gathers interrupt events from a set of network sockets and two chip-wide events into one place that software can poll or service from a single interrupt line. Each socket owns a status register. Hardware sets its event bits with one-cycle pulses, and software clears them by writing ones. The common register condenses the sockets into one summary bit each and keeps two global event flags: address conflict and destination unreachable.

A mask register with the same bit layout as the common register selects which common bits may drive the active-low interrupt output. Software reaches every register through a small synchronous read/write port. Read data is registered and arrives one cycle after the address is presented. Whatever produces the events sits outside this block.

Top module: `sock_irq_agg`

## Requirements
- R1: During and after a synchronous reset, every socket status register, both global flags and the mask read as 0, `irq_n` is 1 and `reg_rdata` is 0.
- R2: A 1 on bit b of socket s's slice of `sock_evt` (bits s*EVT_W+b) sets bit b of that socket's status register on the next clock edge. The bit then stays set until software clears it.
- R3: A write to address 2+s clears each bit of socket s's status register where `reg_wdata` holds 1 and leaves the bits where it holds 0.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Bit s (s < NUM_SOCK) of the common register at address 0 is 1 exactly when socket s's status register is non-zero. It returns to 0 as soon as that status register is cleared.
- R6: `conflict_evt` sets common bit 7 and `unreach_evt` sets common bit 6. Writing 1 to either bit at address 0 clears it. A set pulse in the same cycle wins. Written ones at the summary positions have no effect.
- R7: The mask register at address 1 is written and read back as a full byte, using the same bit layout as the common register.
- R8: `irq_n` is 0 exactly when the common register ANDed with the mask is non-zero. It follows a register change with one clock of delay.
- R9: `reg_rdata` presents, one clock after the edge that samples `reg_addr`, the addressed register zero-extended to 8 bits. Unmapped addresses read 0.
- R10: Socket status bits 4 to 6 (phase complete, packet received, authentication failure) are set, cleared and summarised exactly like the basic event bits 0 to 3. Bit 7 of a socket read is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 common, 1 mask, 2+s socket s) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sock_evt | input | NUM_SOCK*EVT_W | Per-socket event set pulses |
| conflict_evt | input | 1 | Address conflict event pulse |
| unreach_evt | input | 1 | Destination unreachable event pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
An event pulse or a write changes the register state at the edge that samples it. A read reflects the new state when its address is presented on the following cycle, and data returns one edge later. `irq_n` moves one edge after the status or mask register changes. The bench therefore drives every input on a falling edge and samples `reg_rdata` on the falling edge that follows the capturing rising edge. It waits one more falling edge before it samples `irq_n`. Masked, no-effect and collision cases are observed through register reads taken before the next stimulus.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_COMMON = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_SOCK0  = 2;
  localparam int BIT_CONFL   = 7;
  localparam int BIT_UNRCH   = 6;
  localparam int MAX_SOCK    = 6;
endpackage

// File: rtl/sia_w1c_reg.sv
module sia_w1c_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~clr_i) | set_i;   // set has priority
  end
endmodule

// File: rtl/sia_irq_gate.sv
module sia_irq_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~|(stat_i & mask_i);
  end
endmodule

// File: rtl/sock_irq_agg.sv
module sock_irq_agg
  import sia_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int EVT_W    = 7,
  parameter int ADDR_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NUM_SOCK*EVT_W-1:0] sock_evt,
  input  logic                      conflict_evt,
  input  logic                      unreach_evt,
  output logic                      irq_n
);
  localparam int PAD_W  = BIT_UNRCH - NUM_SOCK;
  localparam int SPAD_W = DATA_W - EVT_W;

  initial begin
    if (NUM_SOCK > MAX_SOCK || NUM_SOCK < 1) $error("NUM_SOCK out of range");
    if (EVT_W > DATA_W) $error("EVT_W wider than data");
  end

  logic [NUM_SOCK*EVT_W-1:0] stat_flat;
  logic [NUM_SOCK-1:0]       summary;
  logic [1:0]                glob_q;
  logic [DATA_W-1:0]         common_v;
  logic [DATA_W-1:0]         mask_q;
  logic [DATA_W-1:0]         rd_next;

  wire wr_common = reg_we && (reg_addr == ADDR_W'(ADDR_COMMON));
  wire wr_mask   = reg_we && (reg_addr == ADDR_W'(ADDR_MASK));

  // per-socket status registers
  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic             wr_hit;
    logic [EVT_W-1:0] clr;
    assign wr_hit = reg_we && (reg_addr == ADDR_W'(ADDR_SOCK0 + s));
    assign clr    = wr_hit ? reg_wdata[EVT_W-1:0] : '0;
    sia_w1c_reg #(.W(EVT_W)) u_stat (
      .clk  (clk),
      .rst  (rst),
      .set_i(sock_evt[s*EVT_W +: EVT_W]),
      .clr_i(clr),
      .q_o  (stat_flat[s*EVT_W +: EVT_W])
    );
    assign summary[s] = |stat_flat[s*EVT_W +: EVT_W];
  end

  // global flags: [1] conflict, [0] unreachable
  sia_w1c_reg #(.W(2)) u_glob (
    .clk  (clk),
    .rst  (rst),
    .set_i({conflict_evt, unreach_evt}),
    .clr_i(wr_common ? {reg_wdata[BIT_CONFL], reg_wdata[BIT_UNRCH]} : 2'b00),
    .q_o  (glob_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign common_v = {glob_q, {PAD_W{1'b0}}, summary};
    end else begin : g_nopad
      assign common_v = {glob_q, summary};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  sia_irq_gate #(.W(DATA_W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .stat_i (common_v),
    .mask_i (mask_q),
    .irq_n_o(irq_n)
  );

  // read path
  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(ADDR_COMMON)) rd_next = common_v;
    if (reg_addr == ADDR_W'(ADDR_MASK))   rd_next = mask_q;
    for (int s = 0; s < NUM_SOCK; s++) begin
      if (reg_addr == ADDR_W'(ADDR_SOCK0 + s))
        rd_next = DATA_W'({{SPAD_W{1'b0}}, stat_flat[s*EVT_W +: EVT_W]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/sock_irq_agg_chk.sv
module sock_irq_agg_chk
  import sia_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int EVT_W    = 7,
  parameter int ADDR_W   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      reg_we,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic [NUM_SOCK*EVT_W-1:0] sock_evt,
  input logic                      conflict_evt,
  input logic                      unreach_evt,
  input logic [NUM_SOCK*EVT_W-1:0] stat_flat,
  input logic [DATA_W-1:0]         common_v,
  input logic [DATA_W-1:0]         mask_q,
  input logic                      irq_n
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> irq_n);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (sock_evt != '0) |=> ((stat_flat & $past(sock_evt)) == $past(sock_evt)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(ADDR_SOCK0) && sock_evt[EVT_W-1:0] == '0)
    |=> ((stat_flat[EVT_W-1:0] & $past(reg_wdata[EVT_W-1:0])) == '0));

  // R6
  conflict_set_chk: assert property (@(posedge clk) disable iff (rst)
    conflict_evt |=> common_v[BIT_CONFL]);

  // R6
  unreach_set_chk: assert property (@(posedge clk) disable iff (rst)
    unreach_evt |=> common_v[BIT_UNRCH]);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|($past(common_v & mask_q))));
endmodule

bind sock_irq_agg sock_irq_agg_chk #(
  .NUM_SOCK(NUM_SOCK), .EVT_W(EVT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sock_evt(sock_evt), .conflict_evt(conflict_evt),
  .unreach_evt(unreach_evt), .stat_flat(stat_flat), .common_v(common_v),
  .mask_q(mask_q), .irq_n(irq_n)
);

// File: tb/sock_irq_agg_test.sv
`timescale 1ns/1ps
module sock_irq_agg_test;
  localparam int NS = 4;
  localparam int EW = 7;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NS*EW-1:0] sock_evt = '0;
  logic          conflict_evt = 1'b0;
  logic          unreach_evt = 1'b0;
  logic          irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sock_irq_agg #(.NUM_SOCK(NS), .EVT_W(EW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sock_evt(sock_evt),
    .conflict_evt(conflict_evt), .unreach_evt(unreach_evt), .irq_n(irq_n)
  );

  task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string what, input int a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    check(what, reg_rdata, exp);
  endtask

  task automatic irq_check(input string what, input logic exp);
    @(negedge clk);
    @(negedge clk);
    check(what, {7'b0, irq_n}, {7'b0, exp});
  endtask

  task automatic pulse_sock(input int s, input logic [EW-1:0] v);
    @(negedge clk);
    sock_evt[s*EW +: EW] = v;
    @(negedge clk);
    sock_evt = '0;
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", reg_rdata, 8'h00);
    check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    rd_check("R1 common reset", 0, 8'h00);
    rd_check("R1 mask reset", 1, 8'h00);
    rd_check("R1 sock0 reset", 2, 8'h00);
  endtask

  task automatic t_sock_set();
    pulse_sock(1, 7'h04);
    rd_check("R2 sock1 set", 3, 8'h04);
    rd_check("R5 summary sock1", 0, 8'h02);
    irq_check("R8 masked irq stays high", 1'b1);
  endtask

  task automatic t_mask();
    wr(1, 8'h02);
    rd_check("R7 mask readback", 1, 8'h02);
    irq_check("R8 unmasked irq low", 1'b0);
  endtask

  task automatic t_w1c();
    wr(3, 8'h00);
    rd_check("R3 zero write keeps", 3, 8'h04);
    wr(3, 8'h04);
    rd_check("R3 one write clears", 3, 8'h00);
    rd_check("R5 summary auto clear", 0, 8'h00);
    irq_check("R8 irq released", 1'b1);
  endtask

  task automatic t_link();
    pulse_sock(3, 7'h50);
    rd_check("R10 link bits set", 5, 8'h50);
    rd_check("R10 link summary", 0, 8'h08);
    wr(5, 8'h90);
    rd_check("R10 link clear partial", 5, 8'h40);
  endtask

  task automatic t_collide();
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(5); reg_wdata = 8'h41;
    sock_evt[3*EW +: EW] = 7'h01;
    @(negedge clk);
    reg_we = 1'b0; sock_evt = '0;
    rd_check("R4 set wins over clear", 5, 8'h01);
  endtask

  task automatic t_global();
    @(negedge clk); conflict_evt = 1'b1;
    @(negedge clk); conflict_evt = 1'b0;
    rd_check("R6 conflict set", 0, 8'h88);
    @(negedge clk); unreach_evt = 1'b1;
    @(negedge clk); unreach_evt = 1'b0;
    rd_check("R6 unreach set", 0, 8'hC8);
    wr(0, 8'h0F);
    rd_check("R6 summary write no effect", 0, 8'hC8);
    wr(0, 8'h80);
    rd_check("R6 conflict cleared", 0, 8'h48);
    wr(1, 8'h40);
    irq_check("R8 unreach unmasked", 1'b0);
    wr(0, 8'h40);
    rd_check("R6 unreach cleared", 0, 8'h08);
    irq_check("R8 sock3 masked off", 1'b1);
  endtask

  task automatic t_unmapped();
    rd_check("R9 unmapped reads zero", 9, 8'h00);
    rd_check("R9 socket2 idle", 4, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sock_set();
    t_mask();
    t_w1c();
    t_link();
    t_collide();
    t_global();
    t_unmapped();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule